// File: doc/BRIEF.md
# Reference Frame Reconstruction Mux

This block rebuilds the decoded picture that an inter-frame video encoder keeps as the reference for the next frame. Each accepted input beat carries one signed residual sample from the inverse transform, one reference-frame pixel, and two per-block flags that state the frame type and whether the block is coded. The reference pixels enter the block at the moment their block enters the transform pipeline. An internal circular delay line holds them back by a fixed number of accepted beats, so each one meets its own residual sample.

For every 8x8 block of 64 samples the block forms one of three results. For an intra block it outputs the residual plus a level offset of 128. For a coded block in an inter frame it outputs the residual plus the co-located reference pixel. For an uncoded block it passes the reference pixel through unchanged. Every result is saturated to 8 bits. The block also tags each output pixel with its colour plane. Blocks follow the macroblock order of four luma blocks, then one Cb block, then one Cr block.

A single valid/ready handshake on the output stalls the joint input beat. Residual and reference data therefore cannot drift apart.

Top module: `recon_mux_top`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1. The delay line contents read as 0.
- R2: In an intra block, `out_pix` = clamp(residual + 128). The coded flag has no effect.
- R3: In an inter block with the coded flag set, `out_pix` = clamp(residual + delayed reference).
- R4: In an inter block with the coded flag clear, `out_pix` equals the delayed reference pixel, whatever the residual.
- R5: The reference used for accepted beat n is the `in_ref` of accepted beat n-LAT (LAT = 8 by default). For the first LAT beats after reset it is 0.
- R6: `in_intra` (1 = intra) and `in_coded` (1 = coded) are sampled on beat 0 of each 64-beat block and apply to all 64 beats of that block. Their values on beats 1 to 63 have no effect.
- R7: Each accepted input beat (`in_valid` and `in_ready` high at a clock edge) yields exactly one output beat, with `out_valid` high from the next cycle on. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pix` and `out_plane` hold their values.
- R9: `out_plane` encodes the block's position in its 6-block macroblock: 0 for blocks 0 to 3 (luma), 1 for block 4 (Cb), 2 for block 5 (Cr). The value 3 never appears.
- R10: `in_res` is a signed 10-bit two's-complement value. Sums below 0 give 0 and sums above 255 give 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Joint input beat valid |
| in_ready | output | 1 | Joint input beat accepted when high |
| in_res | input | 10 | Signed inverse-transform residual |
| in_ref | input | 8 | Reference pixel, leading its residual by LAT beats |
| in_intra | input | 1 | Frame type, 1 = intra (sampled on beat 0 of a block) |
| in_coded | input | 1 | Block coded flag (sampled on beat 0 of a block) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output pixel |
| out_pix | output | 8 | Reconstructed saturated pixel |
| out_plane | output | 2 | Plane of the output pixel: 0 Y, 1 Cb, 2 Cr |

## Verification
Each result appears one cycle after its input beat is accepted, and it stays on the port until the consumer takes it. The reference it depends on arrives exactly LAT accepted beats earlier, and stalled cycles do not count toward that distance. The bench drives inputs on the falling edge and decides acceptance from `in_ready` at that point. It pushes the expected pixel and plane into a queue for each accepted beat. It pops and compares whenever `out_valid` and `out_ready` are both high on the falling edge. In that way the one-cycle latency and the LAT-beat reference alignment are both checked against beat counts and not wall-clock cycles. Stall stability is checked by comparing the held output on consecutive falling edges.

// File: rtl/recon_pkg.sv
package recon_pkg;

    typedef enum logic [1:0] {
        MODE_INTRA = 2'd0,
        MODE_SUM   = 2'd1,
        MODE_SKIP  = 2'd2
    } recon_mode_e;

    // Saturate a signed intermediate to an 8-bit pixel
    function automatic logic [7:0] sat8(input logic signed [11:0] v);
        logic [7:0] r;
        if (v < 12'sd0)        r = 8'd0;
        else if (v > 12'sd255) r = 8'd255;
        else                   r = v[7:0];
        return r;
    endfunction

    function automatic logic [7:0] rebuild(input recon_mode_e m,
                                           input logic [9:0] res,
                                           input logic [7:0] refp);
        logic signed [11:0] rx;
        logic signed [11:0] rf;
        logic [7:0]         r;
        rx = {{2{res[9]}}, res};
        rf = {4'b0000, refp};
        case (m)
            MODE_INTRA: r = sat8(rx + 12'sd128);
            MODE_SUM:   r = sat8(rx + rf);
            default:    r = refp;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ref_delay_line.sv
module ref_delay_line #(
    parameter int W   = 8,
    parameter int LAT = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int AW    = (LAT < 1) ? 1 : $clog2(LAT + 1);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            ptr_d.wptr = ptr_q.wptr + 1'b1;
            ptr_d.rptr = ptr_q.rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q.wptr <= AW'(LAT);
            ptr_q.rptr <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (adv) begin
            mem[ptr_q.wptr] <= din;
        end
    end

    assign dout = mem[ptr_q.rptr];

endmodule

// File: rtl/blk_sequencer.sv
module blk_sequencer
    import recon_pkg::*;
#(
    parameter int BLK_LEN = 64,
    parameter int MB_BLKS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  logic        flag_intra,
    input  logic        flag_coded,
    output recon_mode_e mode,
    output logic [1:0]  plane
);
    localparam int CW = $clog2(BLK_LEN);
    localparam int BW = $clog2(MB_BLKS);
    localparam logic [CW-1:0] LAST_SMP = CW'(BLK_LEN - 1);
    localparam logic [BW-1:0] LAST_BLK = BW'(MB_BLKS - 1);
    localparam logic [BW-1:0] CB_BLK   = BW'(MB_BLKS - 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [BW-1:0] blk;
        logic          intra;
        logic          coded;
    } seq_t;

    seq_t seq_d, seq_q;
    logic first, eff_intra, eff_coded;

    always_comb begin
        first     = (seq_q.cnt == '0);
        eff_intra = first ? flag_intra : seq_q.intra;
        eff_coded = first ? flag_coded : seq_q.coded;
        if (eff_intra)      mode = MODE_INTRA;
        else if (eff_coded) mode = MODE_SUM;
        else                mode = MODE_SKIP;

        if (seq_q.blk == LAST_BLK)    plane = 2'd2;
        else if (seq_q.blk == CB_BLK) plane = 2'd1;
        else                          plane = 2'd0;

        seq_d = seq_q;
        if (adv) begin
            if (first) begin
                seq_d.intra = flag_intra;
                seq_d.coded = flag_coded;
            end
            seq_d.cnt = seq_q.cnt + 1'b1;
            if (seq_q.cnt == LAST_SMP) begin
                seq_d.cnt = '0;
                seq_d.blk = (seq_q.blk == LAST_BLK) ? '0 : seq_q.blk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    a_r6_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && seq_q.cnt == LAST_SMP) |=> (seq_q.cnt == '0));

    a_r9_plane_range: assert property (@(posedge clk) disable iff (!rst_n)
        plane != 2'd3);

endmodule

// File: rtl/recon_mux_top.sv
module recon_mux_top
    import recon_pkg::*;
#(
    parameter int LAT     = 8,
    parameter int RES_W   = 10,
    parameter int PIX_W   = 8,
    parameter int BLK_LEN = 64,
    parameter int MB_BLKS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [RES_W-1:0] in_res,
    input  logic [PIX_W-1:0] in_ref,
    input  logic             in_intra,
    input  logic             in_coded,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix,
    output logic [1:0]       out_plane
);
    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] pix;
        logic [1:0]       plane;
    } out_t;

    out_t        o_d, o_q;
    logic        adv;
    logic [PIX_W-1:0] ref_dly;
    recon_mode_e mode;
    logic [1:0]  plane;

    assign in_ready = !o_q.valid || out_ready;
    assign adv      = in_valid && in_ready;

    ref_delay_line #(.W(PIX_W), .LAT(LAT)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (adv),
        .din  (in_ref),
        .dout (ref_dly)
    );

    blk_sequencer #(.BLK_LEN(BLK_LEN), .MB_BLKS(MB_BLKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .flag_intra(in_intra),
        .flag_coded(in_coded),
        .mode      (mode),
        .plane     (plane)
    );

    always_comb begin
        o_d = o_q;
        if (adv) begin
            o_d.valid = 1'b1;
            o_d.pix   = rebuild(mode, in_res, ref_dly);
            o_d.plane = plane;
        end else if (out_ready) begin
            o_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign out_pix   = o_q.pix;
    assign out_plane = o_q.plane;

    a_r7_accept_gives_output: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_plane)));

endmodule

// File: tb/tb_recon_mux_top.sv
module tb_recon_mux_top;
    localparam int LAT    = 8;
    localparam int NBLK   = 18;
    localparam int NBEATS = NBLK * 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [9:0] in_res = '0;
    logic [7:0] in_ref = '0;
    logic       in_intra = 1'b0;
    logic       in_coded = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_pix;
    logic [1:0] out_plane;

    int errors = 0;
    int checks = 0;
    int outs   = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int   refq[$];
    int   exp_pix[$];
    int   exp_pl[$];
    string exp_tag[$];

    always #4 clk = ~clk;

    recon_mux_top #(.LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_res(in_res), .in_ref(in_ref), .in_intra(in_intra), .in_coded(in_coded),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_plane(out_plane)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clamp(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic int pick_res(input int pat, input int k);
        case (pat)
            0: return $signed($urandom_range(1023, 0)) - 512;
            1: return k * 12 - 384;
            2: return (k % 2 == 0) ? 511 : -512;
            default: return $signed($urandom_range(40, 0)) - 20;
        endcase
    endfunction

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, NBEATS);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    int  held_pix;
    int  held_pl;
    bit  held = 1'b0;
    int  m_intra, m_coded;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 1);
        for (int i = 0; i < LAT; i++) refq.push_back(0);

        for (int n = 0; n < NBEATS; n++) begin
            automatic int b    = n / 64;
            automatic int k    = n % 64;
            automatic int mode = b % 3;
            automatic int res  = pick_res((b / 3) % 4, k);
            automatic int rf   = (k % 16 == 0) ? 255 : ((k % 16 == 1) ? 0 : int'($urandom_range(255, 0)));
            automatic bit acc  = 1'b0;
            in_res = 10'(res);
            in_ref = 8'(rf);
            if (k == 0) begin
                in_intra = (mode == 0);
                in_coded = (mode == 1) || (mode == 0 && $urandom_range(1, 0) == 1);
            end else begin
                in_intra = $urandom_range(1, 0) == 1;
                in_coded = $urandom_range(1, 0) == 1;
            end
            while (!acc) begin
                in_valid  = ($urandom_range(3, 0) != 0);
                out_ready = ($urandom_range(3, 0) != 0);
                #1;
                if (held && out_valid) begin
                    chk("R8 held pix", int'(out_pix), held_pix);
                    chk("R8 held plane", int'(out_plane), held_pl);
                end
                held = 1'b0;
                chk("R7 in_ready rule", int'(in_ready), int'(!out_valid || out_ready));
                if (out_valid && out_ready) begin
                    if (exp_pix.size() == 0) begin
                        chk("R7 unexpected output", 1, 0);
                    end else begin
                        automatic int    ep = exp_pix.pop_front();
                        automatic int    el = exp_pl.pop_front();
                        automatic string et = exp_tag.pop_front();
                        chk(et, int'(out_pix), ep);
                        chk("R9 plane", int'(out_plane), el);
                        outs++;
                    end
                end else if (out_valid) begin
                    held = 1'b1;
                    held_pix = int'(out_pix);
                    held_pl = int'(out_plane);
                end
                if (in_valid && in_ready) begin
                    automatic int r = refq.pop_front();
                    automatic int e;
                    automatic string t;
                    automatic int bi = b % 6;
                    refq.push_back(rf);
                    if (k == 0) begin
                        m_intra = int'(in_intra);
                        m_coded = int'(in_coded);
                    end
                    if (m_intra != 0) begin
                        e = clamp(res + 128); t = "R2 intra (R6 flags)";
                    end else if (m_coded != 0) begin
                        e = clamp(res + r);   t = "R3 inter sum (R6 flags)";
                    end else begin
                        e = r;                t = "R4 uncoded pass (R6 flags)";
                    end
                    if (m_intra == 0 && m_coded != 0 && (res + r < 0 || res + r > 255))
                        t = "R10 saturation";
                    if (m_intra != 0 && (res + 128 < 0 || res + 128 > 255))
                        t = "R10 saturation";
                    if (n < LAT) t = {t, " R5 early ref zero"};
                    else         t = {t, " R5 delay"};
                    exp_pix.push_back(e);
                    exp_pl.push_back(bi < 4 ? 0 : (bi == 4 ? 1 : 2));
                    exp_tag.push_back(t);
                    acc = 1'b1;
                end
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        // drain
        for (int c = 0; c < 200 && exp_pix.size() > 0; c++) begin
            out_ready = ($urandom_range(1, 0) == 1);
            #1;
            if (out_valid && out_ready) begin
                automatic int    ep = exp_pix.pop_front();
                automatic int    el = exp_pl.pop_front();
                automatic string et = exp_tag.pop_front();
                chk(et, int'(out_pix), ep);
                chk("R9 plane", int'(out_plane), el);
                outs++;
            end
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R7 output count", outs, NBEATS);
        chk("R7 idle after drain", int'(out_valid), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule